// File: doc/BRIEF.md
# Redundant Store Compare Queue

This block holds stores from the leading copy of a redundantly executed program at the edge of the protected region. No leading store reaches the data cache on its own. Each leading store waits in a per-thread FIFO until the trailing copy presents its equivalent store. The trailing store's address and value are then compared with the oldest waiting entry.

When both fields agree, the block issues exactly one cache write carrying the checked address and data, and frees the entry. When either field differs, the block raises a fault that stays set until reset. It suppresses that write and accepts no further trailing stores, so nothing more leaves the region. Results other than stores are outside this block.

The leading thread sees back-pressure when every slot is occupied. The trailing side never depends on free space, so a full queue can always drain.

Top module: `store_check_queue`

## Requirements
- R1: After reset, `lead_ready` is 1, `trail_ready` is 0, `mem_wr_en` is 0 and `fault` is 0.
- R2: A store accepted from the leading thread (`lead_valid` and `lead_ready` both 1 at a clock edge) never by itself causes `mem_wr_en` to rise.
- R3: A trailing store accepted (`trail_valid` and `trail_ready` both 1) whose address and data both equal the oldest held entry gives `mem_wr_en` = 1 for exactly one cycle after that edge, with `mem_wr_addr`/`mem_wr_data` equal to the checked values.
- R4: Trailing stores are checked against held leading stores in the order those were accepted (first in, first out).
- R5: An accepted trailing store whose address or data differs from the oldest entry sets `fault` after that edge and produces no cache write.
- R6: Once set, `fault` stays 1, `trail_ready` stays 0 and `mem_wr_en` stays 0 until reset.
- R7: With DEPTH entries held, `lead_ready` is 0, and a `lead_valid` pulse in that state is ignored: it never appears in a later write.
- R8: `trail_ready` is 1 whenever at least one entry is held and no fault is set, including when the queue is full. A match from a full queue makes `lead_ready` 1 after that edge.
- R9: `trail_ready` is 0 while the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_valid | input | 1 | Leading-thread store offered |
| lead_addr | input | ADDR_W | Leading store address |
| lead_data | input | DATA_W | Leading store value |
| lead_ready | output | 1 | Queue has a free slot |
| trail_valid | input | 1 | Trailing-thread store offered |
| trail_addr | input | ADDR_W | Trailing store address |
| trail_data | input | DATA_W | Trailing store value |
| trail_ready | output | 1 | A held entry is available for comparison |
| mem_wr_en | output | 1 | One-cycle cache write strobe |
| mem_wr_addr | output | ADDR_W | Checked write address |
| mem_wr_data | output | DATA_W | Checked write data |
| fault | output | 1 | Sticky mismatch indication |

## Verification
The bench builds the queue with DEPTH = 4, ADDR_W = 16 and DATA_W = 32. The shallow depth lets the random traffic fill the queue again and again. This exercises pointer wrap, back-pressure with an ignored push, and draining from a full queue. Separate directed runs corrupt the address in one case and the data in another. They then confirm that the fault is sticky and that the block stays silent afterwards.

// File: rtl/scq_pkg.sv
package scq_pkg;
  typedef enum logic [1:0] {
    CMP_IDLE  = 2'd0,
    CMP_MATCH = 2'd1,
    CMP_MISS  = 2'd2
  } cmp_res_e;
endpackage

// File: rtl/scq_store_fifo.sv
module scq_store_fifo #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = ADDR_W + DATA_W;

  // LUT-RAM style storage: synchronous write, asynchronous head read
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {in_addr, in_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign {head_addr, head_data} = mem[rd_ptr];
  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);

  // R7: occupancy never exceeds the configured depth
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= DEPTH);
  // R4: each entry leaves at most once per accepted trailing store
  p_count_track_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> int'(cnt) == int'($past(cnt)) + int'($past(push)) - int'($past(pop)));
  // R9: nothing leaves an empty queue
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    empty |-> !pop);
endmodule

// File: rtl/scq_comparator.sv
module scq_comparator
  import scq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [DATA_W-1:0] chk_data,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [DATA_W-1:0] ref_data,
  output logic              pop,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              fault
);
  cmp_res_e res;

  always_comb begin
    res = CMP_IDLE;
    if (fire) res = ((chk_addr == ref_addr) && (chk_data == ref_data)) ? CMP_MATCH : CMP_MISS;
  end

  assign pop = (res == CMP_MATCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      fault   <= 1'b0;
    end else begin
      wr_en <= (res == CMP_MATCH) && !fault;
      if (res == CMP_MATCH) begin
        wr_addr <= ref_addr;
        wr_data <= ref_data;
      end
      if (res == CMP_MISS) fault <= 1'b1;
    end
  end

  // R6: fault is sticky
  p_fault_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);
  // R6: no cache write once a fault is raised
  p_silent_after_fault_r6: assert property (@(posedge clk) disable iff (rst)
    fault |-> !wr_en);
  // R3: a write strobe lasts one cycle unless another check was accepted
  p_one_shot_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en && !fire |=> !wr_en);
  // R5: a rising fault never comes with a write
  p_miss_no_write_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> !wr_en);
endmodule

// File: rtl/store_check_queue.sv
module store_check_queue #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lead_valid,
  input  logic [ADDR_W-1:0] lead_addr,
  input  logic [DATA_W-1:0] lead_data,
  output logic              lead_ready,
  input  logic              trail_valid,
  input  logic [ADDR_W-1:0] trail_addr,
  input  logic [DATA_W-1:0] trail_data,
  output logic              trail_ready,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic              fault
);
  logic              full, empty, pop, push, fire;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;

  assign lead_ready  = !full;
  assign trail_ready = !empty && !fault;   // independent of full: no deadlock
  assign push        = lead_valid && lead_ready;
  assign fire        = trail_valid && trail_ready;

  scq_store_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .in_addr(lead_addr), .in_data(lead_data),
    .head_addr(head_addr), .head_data(head_data),
    .full(full), .empty(empty)
  );

  scq_comparator #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .fire(fire),
    .chk_addr(trail_addr), .chk_data(trail_data),
    .ref_addr(head_addr), .ref_data(head_data),
    .pop(pop), .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data),
    .fault(fault)
  );

  // R2: every cache write follows an accepted trailing store
  p_write_needs_trail_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) && mem_wr_en |-> $past(trail_valid && trail_ready));
  // R8: a full queue still accepts the trailing store
  p_full_drains_r8: assert property (@(posedge clk) disable iff (rst)
    !lead_ready && !fault |-> trail_ready);
endmodule

// File: tb/store_check_queue_bench.sv
module store_check_queue_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int D  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lead_valid = 1'b0, trail_valid = 1'b0;
  logic [AW-1:0] lead_addr = '0, trail_addr = '0;
  logic [DW-1:0] lead_data = '0, trail_data = '0;
  logic lead_ready, trail_ready, mem_wr_en, fault;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;

  int n_chk = 0, n_bad = 0;
  logic [AW-1:0] q_a [256];
  logic [DW-1:0] q_d [256];
  int q_h = 0, q_t = 0;

  always #4 clk = ~clk;   // 125 MHz

  store_check_queue #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(D)) u_store_check_queue (
    .clk(clk), .rst(rst),
    .lead_valid(lead_valid), .lead_addr(lead_addr), .lead_data(lead_data), .lead_ready(lead_ready),
    .trail_valid(trail_valid), .trail_addr(trail_addr), .trail_data(trail_data), .trail_ready(trail_ready),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .fault(fault)
  );

  function automatic int held();
    return q_t - q_h;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lead_valid = 0; trail_valid = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q_h = 0; q_t = 0;
  endtask

  // drive a leading store for one cycle; model records it only if ready
  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    lead_valid = 1; lead_addr = a; lead_data = d;
    check(lead_ready == (held() < D), "R7", lead_ready, held() < D);
    if (lead_ready) begin q_a[q_t % 256] = a; q_d[q_t % 256] = d; q_t++; end
    @(negedge clk);
    lead_valid = 0;
    check(mem_wr_en == 0, "R2", mem_wr_en, 0);
  endtask

  // drive a trailing store that matches the model head
  task automatic trail_match();
    logic [AW-1:0] ea; logic [DW-1:0] ed;
    ea = q_a[q_h % 256]; ed = q_d[q_h % 256];
    trail_valid = 1; trail_addr = ea; trail_data = ed;
    check(trail_ready == 1, "R8", trail_ready, 1);
    q_h++;
    @(negedge clk);
    trail_valid = 0;
    check(mem_wr_en == 1, "R3", mem_wr_en, 1);
    check(mem_wr_addr == ea && mem_wr_data == ed, "R4",
          {mem_wr_addr, mem_wr_data}, {ea, ed});
    @(negedge clk);
    check(mem_wr_en == 0, "R3", mem_wr_en, 0);
  endtask

  task automatic mismatch_case(input bit on_addr);
    push(16'h1234, 32'hCAFE_0001);
    push(16'h2345, 32'hCAFE_0002);
    trail_valid = 1;
    trail_addr = on_addr ? 16'h1235 : 16'h1234;
    trail_data = on_addr ? 32'hCAFE_0001 : 32'hCAFE_0000;
    @(negedge clk);
    trail_valid = 0;
    check(fault == 1, "R5", fault, 1);
    check(mem_wr_en == 0, "R5", mem_wr_en, 0);
    // correct store offered afterwards must be refused
    trail_valid = 1; trail_addr = 16'h1234; trail_data = 32'hCAFE_0001;
    check(trail_ready == 0, "R6", trail_ready, 0);
    repeat (3) begin
      @(negedge clk);
      check(fault == 1 && mem_wr_en == 0, "R6", {fault, mem_wr_en}, 2'b10);
    end
    trail_valid = 0;
  endtask

  initial begin
    void'($urandom(32'h0005_EED5));
    do_reset();
    check(lead_ready == 1, "R1", lead_ready, 1);
    check(trail_ready == 0, "R1", trail_ready, 0);
    check(mem_wr_en == 0 && fault == 0, "R1", {mem_wr_en, fault}, 0);
    // R9: trailing store offered while empty is held off
    trail_valid = 1; trail_addr = 16'h0; trail_data = 32'h0;
    check(trail_ready == 0, "R9", trail_ready, 0);
    @(negedge clk);
    trail_valid = 0;
    check(mem_wr_en == 0 && fault == 0, "R9", {mem_wr_en, fault}, 0);

    // directed: fill, push while full (ignored), drain one from full
    for (int i = 0; i < D; i++) push(AW'(16'h100 + i), DW'(32'hA000 + i));
    check(lead_ready == 0, "R7", lead_ready, 0);
    push(16'hDEAD, 32'hBAD0_BAD0);            // must be ignored
    check(trail_ready == 1, "R8", trail_ready, 1);
    trail_match();
    check(lead_ready == 1, "R8", lead_ready, 1);
    while (held() > 0) trail_match();          // R4: order incl. no DEAD entry
    check(trail_ready == 0, "R9", trail_ready, 0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      op = $urandom_range(0, 2);
      if (op == 0 || held() == 0) push(AW'($urandom), $urandom);
      else if (op == 1) trail_match();
      else begin
        @(negedge clk);
        check(mem_wr_en == 0, "R2", mem_wr_en, 0);
      end
      check(trail_ready == (held() > 0), "R9", trail_ready, held() > 0);
    end
    while (held() > 0) trail_match();

    do_reset();
    mismatch_case(1'b1);
    do_reset();
    check(fault == 0 && trail_ready == 0, "R1", {fault, trail_ready}, 0);
    mismatch_case(1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule